// File: doc/BRIEF.md
# Memory Request Stretcher and Step Stall

This block connects a processor's step-sequenced control unit to a memory that answers in its own time. The controller gives one-cycle read or write pulses. The block turns each pulse into a level request on the memory side and holds that request until the memory signals completion. A request pulsed in one control step therefore stays visible while the controller moves on to later steps.

The block also produces a run enable for the controller's step counter. The counter may only stop in a step that asks to wait for memory completion. In that step the enable stays low until completion arrives, then goes high at once. In every other step the enable stays high.

The completion input comes from outside the clock domain. It passes through a flop chain, two stages by default, before it clears a request or releases a stall. If a new pulse and a clearing completion arrive in the same cycle, the new pulse wins.

Top module: `memHandshakeStall`

## Requirements
- R1: While `rstN` is low, and in the cycles after reset until a strobe arrives, `memRead` and `memWrite` are 0.
- R2: `memRead` is 1 in the same cycle as `readStb`, and `memWrite` is 1 in the same cycle as `writeStb`, with no register in between.
- R3: After a read pulse, `memRead` stays 1 in every following cycle until a synchronized completion clears it.
- R4: `mfcAsync` is sampled by `SYNC_STAGES` (default 2) flops. If it is 1 at clock edge k, the synchronized completion is 1 from edge k+1. The held read request is then cleared at edge k+2, so `memRead` reads 0 after that edge unless a new pulse arrives.
- R5: A write pulse holds `memWrite` at 1 in the same way. The same synchronized completion clears it, with the same timing as in R4.
- R6: When `waitMfc` is 1, `run` is 0 until the synchronized completion is 1. In the cycle the synchronized completion becomes 1, `run` is 1.
- R7: If a strobe and the synchronized completion are active in the same cycle, the strobe wins. The request is still held in the next cycle.
- R8: `readStb` and `writeStb` are never 1 together. Such a cycle is flagged as an error.
- R9: When `waitMfc` is 0, `run` is 1, whatever the state of the requests and the completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| readStb | input | 1 | One-cycle read pulse from the controller |
| writeStb | input | 1 | One-cycle write pulse from the controller |
| waitMfc | input | 1 | Current step waits for memory completion |
| mfcAsync | input | 1 | Completion from memory, asynchronous |
| memRead | output | 1 | Held read request to memory |
| memWrite | output | 1 | Held write request to memory |
| run | output | 1 | Step counter enable |

## Verification
The hardest case to reach is a cycle where a fresh strobe lands exactly while the synchronized completion is still high. The completion must be raised two edges before the strobe, and only then does the fight between set and clear appear. The stimulus holds completion high across a whole request, then pulses the strobe again while it is still high. It also varies the completion latency between requests, so that the release of a stall falls at different distances from the original pulse.

// File: rtl/memStallPkg.sv
package memStallPkg;
  typedef struct packed {
    logic setRd;
    logic setWr;
    logic clrReq;
  } reqStrobes_t;

  localparam int NUM_CH = 2;
  localparam int CH_RD  = 0;
  localparam int CH_WR  = 1;
endpackage

// File: rtl/mfcSync.sv
module mfcSync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '0;
        else       chain <= asyncIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[LAST-1:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = chain[LAST];
endmodule

// File: rtl/stallCtrl.sv
module stallCtrl
  import memStallPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        readStb,
  input  logic        writeStb,
  input  logic        waitMfc,
  input  logic        mfcDone,
  output reqStrobes_t strb,
  output logic        run
);
  always_comb begin
    strb.setRd  = readStb;
    strb.setWr  = writeStb;
    strb.clrReq = mfcDone;
    run         = !waitMfc || mfcDone;
  end

  AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(readStb && writeStb)) else $error("read and write strobes together"); // R8

  AST_RUN_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (waitMfc && !run) |=> ($past(waitMfc) && !$past(mfcDone))); // R6
endmodule

// File: rtl/reqDatapath.sv
module reqDatapath
  import memStallPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  reqStrobes_t strb,
  output logic        memRead,
  output logic        memWrite
);
  logic [NUM_CH-1:0] setVec;
  logic [NUM_CH-1:0] reqFf;
  logic [NUM_CH-1:0] reqOut;

  assign setVec[CH_RD] = strb.setRd;
  assign setVec[CH_WR] = strb.setWr;

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      always_ff @(posedge clk) begin
        if (!rstN)            reqFf[ch] <= 1'b0;
        else if (setVec[ch])  reqFf[ch] <= 1'b1;
        else if (strb.clrReq) reqFf[ch] <= 1'b0;
      end
      assign reqOut[ch] = setVec[ch] | reqFf[ch];
    end
  endgenerate

  assign memRead  = reqOut[CH_RD];
  assign memWrite = reqOut[CH_WR];

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memRead && !strb.clrReq) |=> memRead); // R3
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memWrite && !strb.clrReq) |=> memWrite); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setRd && strb.clrReq) |=> memRead); // R7
  AST_CLR_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrReq && !strb.setRd) |=> (!memRead || strb.setRd)); // R4
endmodule

// File: rtl/memHandshakeStall.sv
module memHandshakeStall
  import memStallPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic readStb,
  input  logic writeStb,
  input  logic waitMfc,
  input  logic mfcAsync,
  output logic memRead,
  output logic memWrite,
  output logic run
);
  logic        mfcDone;
  reqStrobes_t strb;

  mfcSync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .asyncIn(mfcAsync), .syncOut(mfcDone)
  );

  stallCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .readStb(readStb), .writeStb(writeStb),
    .waitMfc(waitMfc), .mfcDone(mfcDone), .strb(strb), .run(run)
  );

  reqDatapath i_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .memRead(memRead), .memWrite(memWrite)
  );

  AST_IDLE_RUN: assert property (@(posedge clk) disable iff (!rstN)
    !waitMfc |-> run); // R9
endmodule

// File: tb/test_memHandshakeStall.sv
module test_memHandshakeStall;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic readStb = 1'b0, writeStb = 1'b0, waitMfc = 1'b0, mfcAsync = 1'b0;
  logic memRead, memWrite, run;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  memHandshakeStall i_memHandshakeStall (
    .clk(clk), .rstN(rstN), .readStb(readStb), .writeStb(writeStb),
    .waitMfc(waitMfc), .mfcAsync(mfcAsync),
    .memRead(memRead), .memWrite(memWrite), .run(run)
  );

  // Behavioural reference: completion history queue and pending-request bits
  bit mfcHist[$] = '{0, 0};
  bit pendRd = 0, pendWr = 0;

  always @(posedge clk) begin
    bit done;
    done = mfcHist[0];
    if (!rstN) begin
      pendRd = 0; pendWr = 0;
      mfcHist = '{0, 0};
    end else begin
      if (readStb)   pendRd = 1; else if (done) pendRd = 0;
      if (writeStb)  pendWr = 1; else if (done) pendWr = 0;
      void'(mfcHist.pop_front());
      mfcHist.push_back(mfcAsync);
    end
  end

  task automatic check(input string req, input string name, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, name, act, exp, $time);
    end
  endtask

  task automatic step(input bit r, input bit w, input bit wt, input bit m, input string req);
    @(negedge clk);
    readStb = r; writeStb = w; waitMfc = wt; mfcAsync = m;
    #2;
    check(req, "memRead",  memRead,  r | pendRd);
    check(req, "memWrite", memWrite, w | pendWr);
    check(req, "run",      run,      !wt | mfcHist[0]);
  endtask

  initial begin
    // R1: reset state
    repeat (3) step(0, 0, 0, 0, "R1");
    @(negedge clk); rstN = 1'b1;
    repeat (2) step(0, 0, 0, 0, "R1");

    // R2/R3/R4/R6: read with latency 3, waiting step stalls
    step(1, 0, 0, 0, "R2");
    repeat (3) step(0, 0, 1, 0, "R3");
    step(0, 0, 1, 1, "R6");
    repeat (3) step(0, 0, 1, 0, "R4");
    repeat (2) step(0, 0, 0, 0, "R4");

    // R5: write with latency 6
    step(0, 1, 0, 0, "R5");
    repeat (6) step(0, 0, 1, 0, "R5");
    repeat (2) step(0, 0, 1, 1, "R5");
    repeat (4) step(0, 0, 0, 0, "R5");

    // R7: completion held high, fresh strobe while synced completion is high
    repeat (3) step(0, 0, 0, 1, "R7");
    step(1, 0, 0, 1, "R7");
    step(0, 0, 1, 1, "R7");
    step(0, 1, 0, 1, "R7");
    repeat (3) step(0, 0, 0, 0, "R7");

    // R8: read and write pulses in back-to-back cycles, never together
    step(1, 0, 0, 0, "R8");
    step(0, 1, 0, 0, "R8");
    repeat (2) step(0, 0, 1, 0, "R8");
    step(0, 0, 1, 1, "R8");
    repeat (4) step(0, 0, 0, 0, "R8");

    // R9: waitMfc low keeps run high with requests pending and completion toggling
    step(1, 0, 0, 0, "R9");
    for (int i = 0; i < 8; i++) step(0, 0, 0, i[1], "R9");

    // Varied latencies for R3/R4
    for (int lat = 1; lat < 6; lat++) begin
      step(1, 0, 0, 0, "R3");
      for (int k = 0; k < lat; k++) step(0, 0, 1, 0, "R3");
      step(0, 0, 1, 1, "R4");
      repeat (3) step(0, 0, 1, 0, "R4");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule